// File: doc/BRIEF.md
# Compressing Program-Flow Trace Buffer

This block keeps a short history of where a processor's instruction stream left its sequential path, so that a debugger stopped at a breakpoint can rebuild the exact route the program took. The core presents one retire event per cycle at most. Each event marks a taken jump, call, return or interrupt and carries the address it left from and the address it landed on. Straight-line execution presents no event and leaves no trace. Events raised by iterations of a hardware cache loop carry a flag, and the buffer discards them.

A single-level loop closes with the same backward jump on every pass. The buffer folds those repeats into the one entry written on the first pass, so a long-running loop takes one slot rather than the whole store. When the inner loop of a two-level nest is a cache loop, the inner passes are dropped and the outer jump folds the same way, so the nest also takes one slot. The store holds eight entries in a ring. A new entry replaces the oldest one once the ring is full. While the break input is high the contents do not change. A debugger reads the store through an index in which 0 selects the newest entry.

Top module: `trace_flow_buffer`

## Requirements
- R1: After reset, fill_count is 0 and rd_hit is low for every value of rd_idx.
- R2: An accepted call (kind 01), return (kind 10) or interrupt (kind 11) writes one new entry. That entry appears at rd_idx 0 after the next rising clock edge, and fill_count rises by one unless the store is already full.
- R3: A cycle with ev_valid low changes neither fill_count nor any entry.
- R4: An accepted jump (kind 00) writes no entry when the newest stored entry is a jump with the same source and target addresses. Any other accepted jump writes a new entry.
- R5: An event with ev_cache high changes neither fill_count nor any entry, whatever its kind or addresses.
- R6: A two-level loop writes exactly one entry, however many outer passes it makes, when its inner passes carry ev_cache high and every outer pass ends with the same jump.
- R7: The store holds DEPTH entries (8 by default). fill_count saturates at DEPTH, and each entry written while the store is full replaces the oldest one.
- R8: While halt is high, no event changes fill_count or any entry.
- R9: For rd_idx below fill_count, rd_hit is high and the read outputs show the entry that is rd_idx places older than the newest. For any other rd_idx, rd_hit is low and rd_kind, rd_src and rd_dst are all zero.
- R10: Each entry returns, unchanged, the 2-bit kind code (00 jump, 01 call, 10 return, 11 interrupt) and the source and target addresses it was written with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | A retired discontinuity is presented this cycle |
| ev_kind | input | 2 | Kind code: 00 jump, 01 call, 10 return, 11 interrupt |
| ev_src | input | ADDR_W | Address the flow left from |
| ev_dst | input | ADDR_W | Address the flow went to |
| ev_cache | input | 1 | Event belongs to a cache-loop pass and must be dropped |
| halt | input | 1 | Break active: recording frozen |
| rd_idx | input | $clog2(DEPTH) | Read index, 0 = newest entry |
| rd_hit | output | 1 | The indexed entry holds valid data |
| rd_kind | output | 2 | Kind code of the indexed entry |
| rd_src | output | ADDR_W | Source address of the indexed entry |
| rd_dst | output | ADDR_W | Target address of the indexed entry |
| fill_count | output | $clog2(DEPTH+1) | Number of valid entries |

## Verification
The read port is combinational from the stored state. A wrong write pointer, count or slot therefore shows at the read outputs in the half-cycle after the edge that corrupted it, as soon as the index points at the affected position. A fold decision that goes the wrong way shows at once as a fill_count one too high or one too low, and as shifted data at every index past 0. A wraparound fault shows only after the ninth entry. For that reason the reference model is compared at every index on every clock, across several full passes of the ring.

// File: rtl/trace_pkg.sv
package trace_pkg;

    typedef enum logic [1:0] {
        KIND_JUMP = 2'b00,
        KIND_CALL = 2'b01,
        KIND_RET  = 2'b10,
        KIND_IRQ  = 2'b11
    } flow_kind_e;

endpackage

// File: rtl/trace_classify.sv
module trace_classify #(
    parameter int ADDR_W = 16
) (
    input  logic              ev_valid,
    input  logic [1:0]        ev_kind,
    input  logic [ADDR_W-1:0] ev_src,
    input  logic [ADDR_W-1:0] ev_dst,
    input  logic              ev_cache,
    input  logic              halt,
    input  logic              have_last,
    input  logic [1:0]        last_kind,
    input  logic [ADDR_W-1:0] last_src,
    input  logic [ADDR_W-1:0] last_dst,
    output logic              do_write
);
    import trace_pkg::*;

    logic accept;
    logic is_jump;
    logic same_edge;
    logic fold;

    always_comb begin
        // Cache-loop passes and frozen cycles never reach the store.
        accept    = ev_valid && !ev_cache && !halt;
        is_jump   = (ev_kind == KIND_JUMP);
        // A repeated closing jump of a single-level loop matches the newest entry.
        same_edge = have_last && (last_kind == KIND_JUMP)
                    && (last_src == ev_src) && (last_dst == ev_dst);
        fold      = is_jump && same_edge;
        do_write  = accept && !fold;
    end

endmodule

// File: rtl/trace_store.sv
module trace_store #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [1:0]                          wr_kind,
    input  logic [ADDR_W-1:0]                   wr_src,
    input  logic [ADDR_W-1:0]                   wr_dst,
    output logic [DEPTH*(2*ADDR_W+2)-1:0]       slots_flat,
    output logic [$clog2(DEPTH)-1:0]            wr_ptr,
    output logic [$clog2(DEPTH+1)-1:0]          count,
    output logic                                have_last,
    output logic [1:0]                          last_kind,
    output logic [ADDR_W-1:0]                   last_src,
    output logic [ADDR_W-1:0]                   last_dst
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [1:0]        kind;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
    } entry_t;

    typedef struct packed {
        entry_t [DEPTH-1:0] slots;
        logic [PTR_W-1:0]   wr;
        logic [CNT_W-1:0]   cnt;
    } state_t;

    state_t           st_d, st_q;
    entry_t           new_ent;
    entry_t           last_ent;
    logic [PTR_W-1:0] prev_d;

    always_comb begin
        st_d        = st_q;
        new_ent.kind = wr_kind;
        new_ent.src  = wr_src;
        new_ent.dst  = wr_dst;
        if (wr_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (st_q.wr == PTR_W'(i)) begin
                    st_d.slots[i] = new_ent;
                end
            end
            st_d.wr = (st_q.wr == PTR_W'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
            if (st_q.cnt != CNT_W'(DEPTH)) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Newest entry sits one slot behind the write pointer.
    always_comb begin
        prev_d   = (st_q.wr == '0) ? PTR_W'(DEPTH - 1) : st_q.wr - 1'b1;
        last_ent = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (prev_d == PTR_W'(i)) begin
                last_ent = st_q.slots[i];
            end
        end
    end

    assign slots_flat = st_q.slots;
    assign wr_ptr     = st_q.wr;
    assign count      = st_q.cnt;
    assign have_last  = (st_q.cnt != '0);
    assign last_kind  = last_ent.kind;
    assign last_src   = last_ent.src;
    assign last_dst   = last_ent.dst;

endmodule

// File: rtl/trace_reader.sv
module trace_reader #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic [DEPTH*(2*ADDR_W+2)-1:0] slots_flat,
    input  logic [$clog2(DEPTH)-1:0]      wr_ptr,
    input  logic [$clog2(DEPTH+1)-1:0]    count,
    input  logic [$clog2(DEPTH)-1:0]      rd_idx,
    output logic                          rd_hit,
    output logic [1:0]                    rd_kind,
    output logic [ADDR_W-1:0]             rd_src,
    output logic [ADDR_W-1:0]             rd_dst
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int ENT_W = 2 * ADDR_W + 2;
    localparam int SUM_W = PTR_W + 2;

    logic [SUM_W-1:0] raw_pos;
    logic [SUM_W-1:0] slot;
    logic [ENT_W-1:0] picked;

    always_comb begin
        // Position of the entry rd_idx places behind the newest one, modulo DEPTH.
        raw_pos = SUM_W'(wr_ptr) + SUM_W'(DEPTH - 1) - SUM_W'(rd_idx);
        slot    = (raw_pos >= SUM_W'(DEPTH)) ? raw_pos - SUM_W'(DEPTH) : raw_pos;
        picked  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot == SUM_W'(i)) begin
                picked = slots_flat[i*ENT_W +: ENT_W];
            end
        end
        rd_hit = (CNT_W'(rd_idx) < count);
        if (!rd_hit) begin
            picked = '0;
        end
        rd_kind = picked[ENT_W-1 -: 2];
        rd_src  = picked[2*ADDR_W-1 -: ADDR_W];
        rd_dst  = picked[ADDR_W-1:0];
    end

endmodule

// File: rtl/trace_flow_buffer.sv
module trace_flow_buffer #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ev_valid,
    input  logic [1:0]                   ev_kind,
    input  logic [ADDR_W-1:0]            ev_src,
    input  logic [ADDR_W-1:0]            ev_dst,
    input  logic                         ev_cache,
    input  logic                         halt,
    input  logic [$clog2(DEPTH)-1:0]     rd_idx,
    output logic                         rd_hit,
    output logic [1:0]                   rd_kind,
    output logic [ADDR_W-1:0]            rd_src,
    output logic [ADDR_W-1:0]            rd_dst,
    output logic [$clog2(DEPTH+1)-1:0]   fill_count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int ENT_W = 2 * ADDR_W + 2;

    logic                    do_write;
    logic [DEPTH*ENT_W-1:0]  slots_flat;
    logic [PTR_W-1:0]        wr_ptr;
    logic [CNT_W-1:0]        count;
    logic                    have_last;
    logic [1:0]              last_kind;
    logic [ADDR_W-1:0]       last_src;
    logic [ADDR_W-1:0]       last_dst;

    trace_classify #(.ADDR_W(ADDR_W)) u_classify (
        .ev_valid  (ev_valid),
        .ev_kind   (ev_kind),
        .ev_src    (ev_src),
        .ev_dst    (ev_dst),
        .ev_cache  (ev_cache),
        .halt      (halt),
        .have_last (have_last),
        .last_kind (last_kind),
        .last_src  (last_src),
        .last_dst  (last_dst),
        .do_write  (do_write)
    );

    trace_store #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (do_write),
        .wr_kind    (ev_kind),
        .wr_src     (ev_src),
        .wr_dst     (ev_dst),
        .slots_flat (slots_flat),
        .wr_ptr     (wr_ptr),
        .count      (count),
        .have_last  (have_last),
        .last_kind  (last_kind),
        .last_src   (last_src),
        .last_dst   (last_dst)
    );

    trace_reader #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_reader (
        .slots_flat (slots_flat),
        .wr_ptr     (wr_ptr),
        .count      (count),
        .rd_idx     (rd_idx),
        .rd_hit     (rd_hit),
        .rd_kind    (rd_kind),
        .rd_src     (rd_src),
        .rd_dst     (rd_dst)
    );

    assign fill_count = count;

endmodule

// File: rtl/trace_flow_checker.sv
module trace_flow_checker #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ev_valid,
    input logic [1:0]                 ev_kind,
    input logic [ADDR_W-1:0]          ev_src,
    input logic [ADDR_W-1:0]          ev_dst,
    input logic                       ev_cache,
    input logic                       halt,
    input logic [$clog2(DEPTH)-1:0]   rd_idx,
    input logic                       rd_hit,
    input logic [1:0]                 rd_kind,
    input logic [ADDR_W-1:0]          rd_src,
    input logic [ADDR_W-1:0]          rd_dst,
    input logic [$clog2(DEPTH+1)-1:0] fill_count
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic accepted;
    logic view_same;
    assign accepted  = ev_valid && !ev_cache && !halt;

    assert_fill_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_count <= CNT_W'(DEPTH));

    assert_fill_grow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && ev_kind != 2'b00 && fill_count < CNT_W'(DEPTH))
        |=> fill_count == $past(fill_count) + 1'b1);

    assert_newest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && ev_kind != 2'b00)
        |=> (rd_idx != '0) || (rd_hit && rd_kind == $past(ev_kind)
            && rd_src == $past(ev_src) && rd_dst == $past(ev_dst)));

    assign view_same = 1'b1;

    assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_valid |=> $stable(fill_count)
            && (!$stable(rd_idx) || ($stable(rd_src) && $stable(rd_dst) && $stable(rd_kind))));

    assert_cache_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_cache) |=> $stable(fill_count)
            && (!$stable(rd_idx) || ($stable(rd_src) && $stable(rd_dst) && $stable(rd_kind))));

    assert_halt_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> $stable(fill_count)
            && (!$stable(rd_idx) || ($stable(rd_src) && $stable(rd_dst) && $stable(rd_kind))));

    assert_loop_fold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && view_same && ev_kind == 2'b00 && rd_idx == '0 && rd_hit
         && rd_kind == 2'b00 && rd_src == ev_src && rd_dst == ev_dst)
        |=> $stable(fill_count));

endmodule

bind trace_flow_buffer trace_flow_checker #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid   (ev_valid),
    .ev_kind    (ev_kind),
    .ev_src     (ev_src),
    .ev_dst     (ev_dst),
    .ev_cache   (ev_cache),
    .halt       (halt),
    .rd_idx     (rd_idx),
    .rd_hit     (rd_hit),
    .rd_kind    (rd_kind),
    .rd_src     (rd_src),
    .rd_dst     (rd_dst),
    .fill_count (fill_count)
);

// File: tb/tb_trace_flow_buffer.sv
module tb_trace_flow_buffer;
    localparam int CLK_PERIOD = 20;
    localparam int ADDR_W     = 16;
    localparam int DEPTH      = 8;
    localparam int PTR_W      = $clog2(DEPTH);
    localparam int CNT_W      = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ev_valid = 1'b0;
    logic [1:0]        ev_kind = 2'b00;
    logic [ADDR_W-1:0] ev_src = '0;
    logic [ADDR_W-1:0] ev_dst = '0;
    logic              ev_cache = 1'b0;
    logic              halt = 1'b0;
    logic [PTR_W-1:0]  rd_idx = '0;
    logic              rd_hit;
    logic [1:0]        rd_kind;
    logic [ADDR_W-1:0] rd_src;
    logic [ADDR_W-1:0] rd_dst;
    logic [CNT_W-1:0]  fill_count;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Reference model: newest entry at the front of each queue.
    logic [1:0]        mk[$];
    logic [ADDR_W-1:0] ms[$];
    logic [ADDR_W-1:0] md[$];

    trace_flow_buffer #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_kind(ev_kind),
        .ev_src(ev_src), .ev_dst(ev_dst), .ev_cache(ev_cache), .halt(halt),
        .rd_idx(rd_idx), .rd_hit(rd_hit), .rd_kind(rd_kind), .rd_src(rd_src),
        .rd_dst(rd_dst), .fill_count(fill_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic model_update();
        if (ev_valid && !ev_cache && !halt) begin
            if (ev_kind == 2'b00 && mk.size() > 0 && mk[0] == 2'b00
                && ms[0] == ev_src && md[0] == ev_dst) begin
                // folded loop pass: nothing written
            end else begin
                mk.push_front(ev_kind);
                ms.push_front(ev_src);
                md.push_front(ev_dst);
                if (mk.size() > DEPTH) begin
                    void'(mk.pop_back());
                    void'(ms.pop_back());
                    void'(md.pop_back());
                end
            end
        end
    endtask

    // Called in the low clock phase; sweeps every read index (R9, R10).
    task automatic compare(input string tag);
        chk(int'(fill_count) == mk.size(), tag, "fill_count", int'(fill_count), mk.size());
        for (int i = 0; i < DEPTH; i++) begin
            bit hit_e;
            rd_idx = PTR_W'(i);
            #1;
            hit_e = (i < mk.size());
            if (hit_e) begin
                chk(rd_hit && rd_kind == mk[i] && rd_src == ms[i] && rd_dst == md[i],
                    tag, $sformatf("R9 idx %0d {hit,kind,src,dst}", i),
                    int'({rd_hit, rd_kind, rd_src}), int'({1'b1, mk[i], ms[i]}));
            end else begin
                chk(!rd_hit && rd_kind == 2'b00 && rd_src == '0 && rd_dst == '0,
                    tag, $sformatf("R9 idx %0d empty", i),
                    int'({rd_hit, rd_kind, rd_src}), 0);
            end
        end
    endtask

    task automatic step(input logic v, input logic [1:0] k, input logic [ADDR_W-1:0] s,
                        input logic [ADDR_W-1:0] d, input logic c, input logic h,
                        input string tag);
        ev_valid = v; ev_kind = k; ev_src = s; ev_dst = d; ev_cache = c; halt = h;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (CLK_PERIOD * 100000) #1;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL all-requirements watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare("R1");

        // R3: sequential execution leaves nothing
        for (int i = 0; i < 3; i++) step(1'b0, 2'b01, 16'h1234, 16'h5678, 1'b0, 1'b0, "R3");

        // R2 / R10: call, interrupt, return
        step(1'b1, 2'b01, 16'h0100, 16'h0800, 1'b0, 1'b0, "R2");
        step(1'b1, 2'b11, 16'h0804, 16'h0040, 1'b0, 1'b0, "R10");
        step(1'b1, 2'b10, 16'h0060, 16'h0805, 1'b0, 1'b0, "R2");

        // R4: single-level loop folds to one entry
        for (int i = 0; i < 5; i++) step(1'b1, 2'b00, 16'h0900, 16'h0880, 1'b0, 1'b0, "R4");
        step(1'b1, 2'b00, 16'h0900, 16'h0884, 1'b0, 1'b0, "R4");
        step(1'b1, 2'b00, 16'h0900, 16'h0880, 1'b0, 1'b0, "R4");
        // R4: jump matching a call entry is still written
        step(1'b1, 2'b01, 16'h0A00, 16'h0B00, 1'b0, 1'b0, "R4");
        step(1'b1, 2'b00, 16'h0A00, 16'h0B00, 1'b0, 1'b0, "R4");

        // R5: cache-loop events dropped, all kinds
        for (int i = 0; i < 4; i++)
            step(1'b1, 2'(i), 16'h0D00 + 16'(i), 16'h0E00, 1'b1, 1'b0, "R5");

        // R6: two-level loop with cache inner loop
        for (int p = 0; p < 4; p++) begin
            step(1'b1, 2'b00, 16'h0C10, 16'h0C08, 1'b1, 1'b0, "R6");
            step(1'b1, 2'b00, 16'h0C10, 16'h0C08, 1'b1, 1'b0, "R6");
            step(1'b1, 2'b00, 16'h0C20, 16'h0C00, 1'b0, 1'b0, "R6");
        end

        // R8: frozen while halted
        step(1'b1, 2'b01, 16'h0F00, 16'h0F80, 1'b0, 1'b1, "R8");
        step(1'b1, 2'b00, 16'h0F10, 16'h0F90, 1'b0, 1'b1, "R8");
        step(1'b1, 2'b11, 16'h0F20, 16'h0FA0, 1'b0, 1'b1, "R8");
        step(1'b0, 2'b10, 16'h0F30, 16'h0FB0, 1'b0, 1'b1, "R8");

        // R7: overfill wraps and drops the oldest
        for (int i = 0; i < 11; i++)
            step(1'b1, 2'(1 + i % 3), 16'h2000 + 16'(i * 4), 16'h3000 + 16'(i), 1'b0, 1'b0, "R7");

        // R4 after wrap: fold still works across the ring boundary
        for (int i = 0; i < 3; i++) step(1'b1, 2'b00, 16'h4400, 16'h4300, 1'b0, 1'b0, "R4");
        step(1'b0, 2'b00, 16'h0000, 16'h0000, 1'b0, 1'b0, "R3");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule